// File: doc/BRIEF.md
# Strobe-Controlled Status and Error Flag Register

This block holds the status word of a serial-port controller. Its operating-mode bit, its master-select bit and its error flags cannot be written directly. Software changes them through one write-only strobe word. Each flag owns a clear bit and a set bit in that word. A bit written as zero leaves its flag alone, so one access can touch any mix of flags without a read-modify-write.

Error events reported by the shift engine and the FIFOs also set the error flags. Each event passes only when its enable bit is high. The mode bit drives a two-state machine: `CFG_MODE` (mode bit clear, settings may change) and `RUN_MODE` (mode bit set). The transition `GO_RUN` is taken on a set-mode strobe with no clear-mode strobe. The transition `GO_CFG` is taken on a clear-mode strobe with no set-mode strobe. In all other cases the machine stays in its state.

A configuration write request is granted only while the machine is in `CFG_MODE`. The error interrupt is a level equal to the OR of all error flags.

Top module: `ser_flag_status`

## Requirements
- R1: After reset the status word is 0x0000, the machine is in `CFG_MODE`, `err_irq` is 0 and `cfg_mode` is 1.
- R2: Strobe bit 1 sets the mode bit (status bit 0, `GO_RUN`). Strobe bit 0 clears it (`GO_CFG`). The change is visible one clock after the write.
- R3: Strobe bit 3 sets the master-select flag (status bit 1). Strobe bit 2 clears it.
- R4: The error flags use these clear/set strobe bits and status bits:
  - transmit error: clear 8, set 12, status 8
  - receive error: clear 9, set 13, status 9
  - abort error: clear 10, set 14, status 10
  - transmit underflow: clear 11, set 15, status 11
  - receive underflow: clear 4, set 5, status 12
  - mode error: clear 6, set 7, status 2
- R5: When one write carries both the set bit and the clear bit of the same flag, that flag keeps its value.
- R6: Writing 0x0F50 clears all six error flags in one access and leaves the mode and master-select bits unchanged.
- R7: `hw_err_evt` and `hw_err_en` bits 0..4 are transmit overflow, receive overflow, abort, transmit underflow and receive underflow. They set status bits 8, 9, 10, 11 and 12. An event whose enable bit is 0 has no effect.
- R8: An enabled error event in the same cycle as a software clear of the same flag leaves the flag set.
- R9: `err_irq` is 1 exactly while at least one error flag is set. It stays high until software clears the flags.
- R10: Status bit 13 follows `busy_in` in the same cycle. All other unlisted status bits read 0.
- R11: `cfg_wr_grant` is `cfg_wr_req` while in `CFG_MODE` and 0 while in `RUN_MODE`.
- R12: When `strobe_we` is 0, `strobe_word` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_we | input | 1 | Strobe word write enable |
| strobe_word | input | 16 | Paired set/clear strobe bits |
| hw_err_evt | input | 5 | Error event pulses from the shift engine and FIFOs |
| hw_err_en | input | 5 | Per-event enable bits |
| busy_in | input | 1 | Transfer-in-progress indication |
| cfg_wr_req | input | 1 | Request to change a configuration setting |
| status_word | output | 16 | Status word |
| err_irq | output | 1 | Error interrupt request level |
| cfg_mode | output | 1 | 1 while in `CFG_MODE` |
| cfg_wr_grant | output | 1 | Configuration write permitted |

## Verification
The bench builds the block with its default parameters: a 16-bit strobe word and status word, and five hardware error sources. With these values every strobe bit position and every event-to-flag mapping is reachable. This includes the receive-underflow pair, whose strobe bits sit apart from the other error pairs. The vector table walks every flag through set, clear, simultaneous set-and-clear and the bulk 0x0F50 clear. Directed steps then cover busy pass-through and the configuration write grant in both states.

// File: rtl/ser_flag_pkg.sv
package ser_flag_pkg;
    localparam int STROBE_W = 16;
    localparam int STATUS_W = 16;
    localparam int NUM_HW   = 5;

    // mode and master-select strobe and status positions
    localparam int MODE_CLR = 0;
    localparam int MODE_SET = 1;
    localparam int MS_CLR   = 2;
    localparam int MS_SET   = 3;
    localparam int ST_MODE  = 0;
    localparam int ST_MS    = 1;
    localparam int ST_BUSY  = 13;

    // mode-error flag: software only
    localparam int ME_CLR   = 6;
    localparam int ME_SET   = 7;
    localparam int ST_ME    = 2;

    // hardware-fed error flags, index = event index
    localparam int ERR_CLR [NUM_HW] = '{8, 9, 10, 11, 4};
    localparam int ERR_SET [NUM_HW] = '{12, 13, 14, 15, 5};
    localparam int ERR_ST  [NUM_HW] = '{8, 9, 10, 11, 12};

    typedef enum logic {
        CFG_MODE = 1'b0,
        RUN_MODE = 1'b1
    } mode_state_t;
endpackage

// File: rtl/ser_flag_cell.sv
module ser_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_set,
    input  logic sw_clr,
    input  logic hw_set,
    output logic q
);
    logic q_nxt;

    always_comb begin
        q_nxt = q;
        if (hw_set)
            q_nxt = 1'b1;
        else if (sw_set && !sw_clr)
            q_nxt = 1'b1;
        else if (sw_clr && !sw_set)
            q_nxt = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= 1'b0;
        else
            q <= q_nxt;
    end

    AST_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set |=> q);                                                // R8
    AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_set && sw_clr && !hw_set) |=> (q == $past(q)));            // R5
endmodule

// File: rtl/ser_mode_fsm.sv
module ser_mode_fsm
    import ser_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_run,
    input  logic go_cfg,
    output logic run_bit,
    output logic in_cfg
);
    mode_state_t state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            CFG_MODE: if (go_run && !go_cfg) state_nxt = RUN_MODE;
            RUN_MODE: if (go_cfg && !go_run) state_nxt = CFG_MODE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= CFG_MODE;
        else
            state <= state_nxt;
    end

    always_comb begin
        run_bit = 1'b0;
        in_cfg  = 1'b0;
        unique case (state)
            CFG_MODE: in_cfg  = 1'b1;
            RUN_MODE: run_bit = 1'b1;
        endcase
    end

    AST_CLR_TO_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (go_cfg && !go_run) |=> (state == CFG_MODE));                  // R2
    AST_SET_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (go_run && !go_cfg) |=> (state == RUN_MODE));                  // R2
endmodule

// File: rtl/ser_flag_status.sv
module ser_flag_status
    import ser_flag_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strobe_we,
    input  logic [STROBE_W-1:0] strobe_word,
    input  logic [NUM_HW-1:0]   hw_err_evt,
    input  logic [NUM_HW-1:0]   hw_err_en,
    input  logic                busy_in,
    input  logic                cfg_wr_req,
    output logic [STATUS_W-1:0] status_word,
    output logic                err_irq,
    output logic                cfg_mode,
    output logic                cfg_wr_grant
);
    logic [STROBE_W-1:0] stb;
    logic [NUM_HW-1:0]   hw_flag;
    logic                ms_flag;
    logic                me_flag;
    logic                run_bit;

    // R12: strobes only act with the write enable
    assign stb = strobe_we ? strobe_word : '0;

    ser_mode_fsm u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_run  (stb[MODE_SET]),
        .go_cfg  (stb[MODE_CLR]),
        .run_bit (run_bit),
        .in_cfg  (cfg_mode)
    );

    ser_flag_cell u_ms (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_set (stb[MS_SET]),
        .sw_clr (stb[MS_CLR]),
        .hw_set (1'b0),
        .q      (ms_flag)
    );

    ser_flag_cell u_me (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_set (stb[ME_SET]),
        .sw_clr (stb[ME_CLR]),
        .hw_set (1'b0),
        .q      (me_flag)
    );

    for (genvar i = 0; i < NUM_HW; i++) begin : g_err
        ser_flag_cell u_err (
            .clk    (clk),
            .rst_n  (rst_n),
            .sw_set (stb[ERR_SET[i]]),
            .sw_clr (stb[ERR_CLR[i]]),
            .hw_set (hw_err_evt[i] & hw_err_en[i]),
            .q      (hw_flag[i])
        );

        AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            (!hw_err_en[i] && !stb[ERR_SET[i]] && !hw_flag[i]) |=> !hw_flag[i]); // R7
    end

    always_comb begin
        status_word          = '0;
        status_word[ST_MODE] = run_bit;
        status_word[ST_MS]   = ms_flag;
        status_word[ST_ME]   = me_flag;
        status_word[ST_BUSY] = busy_in;
        for (int i = 0; i < NUM_HW; i++)
            status_word[ERR_ST[i]] = hw_flag[i];
    end

    assign err_irq      = me_flag | (|hw_flag);
    assign cfg_wr_grant = cfg_wr_req & cfg_mode;

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (err_irq && !strobe_we) |=> err_irq);                          // R9
    AST_GRANT_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_grant |-> !status_word[ST_MODE]);                       // R11
    AST_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_we && hw_err_evt == '0) |=> $stable(status_word[ST_ME:ST_MODE])); // R12
endmodule

// File: tb/ser_flag_status_bench.sv
`timescale 1ns/1ps
module ser_flag_status_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe_we = 1'b0;
    logic [15:0] strobe_word = '0;
    logic [4:0]  hw_err_evt = '0;
    logic [4:0]  hw_err_en = '0;
    logic        busy_in = 1'b0;
    logic        cfg_wr_req = 1'b0;
    logic [15:0] status_word;
    logic        err_irq, cfg_mode, cfg_wr_grant;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ser_flag_status u_ser_flag_status (
        .clk(clk), .rst_n(rst_n), .strobe_we(strobe_we), .strobe_word(strobe_word),
        .hw_err_evt(hw_err_evt), .hw_err_en(hw_err_en), .busy_in(busy_in),
        .cfg_wr_req(cfg_wr_req), .status_word(status_word), .err_irq(err_irq),
        .cfg_mode(cfg_mode), .cfg_wr_grant(cfg_wr_grant)
    );

    // {we, word, evt, en, expected status, expected irq}
    localparam int NV = 20;
    localparam logic [43:0] VEC [NV] = '{
        {1'b1, 16'h0002, 5'h00, 5'h00, 16'h0001, 1'b0}, // R2 go run
        {1'b1, 16'h0008, 5'h00, 5'h00, 16'h0003, 1'b0}, // R3 set ms
        {1'b1, 16'hF000, 5'h00, 5'h00, 16'h0F03, 1'b1}, // R4 set TE RE AE TUE
        {1'b1, 16'h0020, 5'h00, 5'h00, 16'h1F03, 1'b1}, // R4 set RUE
        {1'b1, 16'h0080, 5'h00, 5'h00, 16'h1F07, 1'b1}, // R4 set mode error
        {1'b1, 16'h0F50, 5'h00, 5'h00, 16'h0003, 1'b0}, // R6 bulk clear
        {1'b1, 16'h1100, 5'h00, 5'h00, 16'h0003, 1'b0}, // R5 pair on clear flag
        {1'b1, 16'h1000, 5'h00, 5'h00, 16'h0103, 1'b1}, // R4 set TE
        {1'b1, 16'h1100, 5'h00, 5'h00, 16'h0103, 1'b1}, // R5 pair on set flag
        {1'b0, 16'h0000, 5'h1F, 5'h00, 16'h0103, 1'b1}, // R7 all gated off
        {1'b1, 16'h0100, 5'h00, 5'h00, 16'h0003, 1'b0}, // R9 irq drops
        {1'b0, 16'h0000, 5'h05, 5'h1F, 16'h0503, 1'b1}, // R7 tx ovf, abort
        {1'b1, 16'h0400, 5'h04, 5'h04, 16'h0503, 1'b1}, // R8 hw beats clear
        {1'b0, 16'h0F50, 5'h00, 5'h00, 16'h0503, 1'b1}, // R12 no we
        {1'b1, 16'h0F50, 5'h00, 5'h00, 16'h0003, 1'b0}, // R6
        {1'b0, 16'h0000, 5'h18, 5'h18, 16'h1803, 1'b1}, // R7 underflows
        {1'b1, 16'h0F50, 5'h00, 5'h00, 16'h0003, 1'b0}, // R6
        {1'b1, 16'h0003, 5'h00, 5'h00, 16'h0003, 1'b0}, // R5 mode pair
        {1'b1, 16'h0001, 5'h00, 5'h00, 16'h0002, 1'b0}, // R2 go cfg
        {1'b1, 16'h0004, 5'h00, 5'h00, 16'h0000, 1'b0}  // R3 clear ms
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 status", {16'h0, status_word}, 32'h0);
        check("R1 irq", {31'h0, err_irq}, 32'h0);
        check("R1 cfg_mode", {31'h0, cfg_mode}, 32'h1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            strobe_we   = VEC[v][43];
            strobe_word = VEC[v][42:27];
            hw_err_evt  = VEC[v][26:22];
            hw_err_en   = VEC[v][21:17];
            @(negedge clk);
            check($sformatf("R4 vec%0d status", v), {16'h0, status_word}, {16'h0, VEC[v][16:1]});
            check($sformatf("R9 vec%0d irq", v), {31'h0, err_irq}, {31'h0, VEC[v][0]});
        end
        strobe_we = 1'b0; strobe_word = '0; hw_err_evt = '0; hw_err_en = '0;

        // R10 busy pass-through, same cycle
        busy_in = 1'b1;
        #1;
        check("R10 busy set", {16'h0, status_word}, 32'h2000);
        busy_in = 1'b0;
        #1;
        check("R10 busy clear", {16'h0, status_word}, 32'h0000);

        // R11 grant in config mode
        cfg_wr_req = 1'b1;
        #1;
        check("R11 grant cfg", {31'h0, cfg_wr_grant}, 32'h1);
        @(negedge clk);
        strobe_we = 1'b1; strobe_word = 16'h0002;
        @(negedge clk);
        strobe_we = 1'b0; strobe_word = '0;
        check("R11 grant run", {31'h0, cfg_wr_grant}, 32'h0);
        check("R2 cfg_mode run", {31'h0, cfg_mode}, 32'h0);
        cfg_wr_req = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule